// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger

This block holds the write-only FIFO control register of a 16550-style UART, together with the two 16-entry, 8-bit FIFOs that the register governs. A CPU writes the register through a single-cycle write strobe and an 8-bit data bus. One write can do several things. It turns buffered operation on or off. It can empty either FIFO with a self-clearing command bit. It selects DMA mode 0 or 1. It picks the receive occupancy at which the receive-data-available interrupt is raised.

The receive FIFO is filled by the serial side and drained by CPU reads. The transmit FIFO is filled by CPU writes and drained by the serial side. Both FIFOs present their oldest entry on the read data port. A push into a full FIFO is discarded and reported with a one-cycle overrun pulse. The DMA mode appears only as a status output.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, fifo_en, dma_mode, rx_irq, rx_overrun and tx_overrun are 0, and rx_count and tx_count are 0.
- R2: A register write with bit 0 set makes fifo_en 1 and sets dma_mode to the written bit 3. Both outputs show the new values in the cycle after the write edge.
- R3: A register write with bit 0 clear makes fifo_en and dma_mode 0. Bits 1, 2, 3, 6 and 7 of that write have no effect: neither FIFO count changes.
- R4: A write with bits 0 and 1 set empties the receive FIFO at the clock edge after the write edge. The command does not repeat: a push accepted in the following cycle is kept.
- R5: A write with bits 0 and 2 set empties the transmit FIFO at the clock edge after the write edge. The receive FIFO is not affected.
- R6: Written bits 4 and 5 are ignored. A write of 0x31 behaves like a write of 0x01.
- R7: While fifo_en is 1, rx_irq is 1 exactly when rx_count is at least the trigger level. Bits 7:6 select the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R8: While fifo_en is 0, the trigger level is 1, so rx_irq is 1 whenever rx_count is nonzero.
- R9: Each FIFO is first-in first-out. Its read data port shows the oldest entry whenever the count is nonzero. The count rises on an accepted push and falls on an accepted pop, and it never exceeds 16.
- R10: A push into a full FIFO (count 16) is discarded and the count stays at 16. The FIFO's overrun output is 1 for the single cycle that follows that push edge.
- R11: A pop from an empty FIFO is ignored and the count stays 0.
- R12: If a FIFO clear takes effect at the same edge as a push, the clear wins and the FIFO ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| rx_push | input | 1 | Serial side delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | CPU reads the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_count | output | 5 | Receive FIFO occupancy |
| rx_overrun | output | 1 | One-cycle pulse: a received byte was dropped |
| tx_push | input | 1 | CPU writes a byte to transmit |
| tx_wdata | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Serial side takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit FIFO occupancy |
| tx_overrun | output | 1 | One-cycle pulse: a transmit byte was dropped |
| fifo_en | output | 1 | Buffered mode is on |
| dma_mode | output | 1 | Selected DMA mode (0 or 1) |
| rx_irq | output | 1 | Receive-data-available interrupt |

## Verification
Some properties are checked on every cycle. The assertions cover the effect of each write on fifo_en and dma_mode, and the two-edge timing of both clear commands. They confirm that an overrun pulse only follows a push into a full FIFO. They also check the interrupt's fixed bounds: low when empty, high at 14 or more, and high on any data while disabled.

Only the bench scenarios can show the rest. The bench sweeps all four trigger levels across every fill and drain step. It checks that data comes out in order, and that bits 4 and 5 and a disabled write leave both FIFOs untouched. It also shows that a clear beats a push landing on the same edge.

// File: rtl/ufc_pkg.sv
`timescale 1ns/1ps
package ufc_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_EN    = 0;
  localparam int BIT_RXCLR = 1;
  localparam int BIT_TXCLR = 2;
  localparam int BIT_DMA   = 3;
  localparam int TRIG_LSB  = 6;

  typedef enum logic [1:0] {
    TRIG_L1  = 2'b00,
    TRIG_L4  = 2'b01,
    TRIG_L8  = 2'b10,
    TRIG_L14 = 2'b11
  } trig_e;

  function automatic int unsigned trig_bytes(trig_e t);
    case (t)
      TRIG_L1:  return 1;
      TRIG_L4:  return 4;
      TRIG_L8:  return 8;
      default:  return 14;
    endcase
  endfunction
endpackage

// File: rtl/ufc_ctrl_reg.sv
`timescale 1ns/1ps
module ufc_ctrl_reg
  import ufc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             en_q,
  output logic             dma_q,
  output trig_e            trig_q,
  output logic             rx_clr_q,
  output logic             tx_clr_q
);
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[5:4];

  logic wr_en;
  assign wr_en = wr && wdata[BIT_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      dma_q    <= 1'b0;
      trig_q   <= TRIG_L1;
      rx_clr_q <= 1'b0;
      tx_clr_q <= 1'b0;
    end else begin
      rx_clr_q <= wr_en && wdata[BIT_RXCLR];
      tx_clr_q <= wr_en && wdata[BIT_TXCLR];
      if (wr) begin
        en_q <= wdata[BIT_EN];
        if (wdata[BIT_EN]) begin
          dma_q  <= wdata[BIT_DMA];
          trig_q <= trig_e'(wdata[TRIG_LSB +: 2]);
        end else begin
          dma_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ufc_fifo.sv
`timescale 1ns/1ps
module ufc_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              full, wr_ok, rd_ok;

  assign full  = (count == CNT_W'(DEPTH));
  assign wr_ok = push && !full && !clr;
  assign rd_ok = pop && (count != '0) && !clr;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (rd_ok) rp <= rp + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drop <= 1'b0;
    else     drop <= push && full && !clr;
  end
endmodule

// File: rtl/ufc_trigger.sv
`timescale 1ns/1ps
module ufc_trigger
  import ufc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             en,
  input  trig_e            trig,
  input  logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] level;
  assign level = en ? CNT_W'(trig_bytes(trig)) : CNT_W'(1);
  assign irq   = (count >= level);
endmodule

// File: rtl/uart_fifo_ctl.sv
`timescale 1ns/1ps
module uart_fifo_ctl
  import ufc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_overrun,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_overrun,
  output logic              fifo_en,
  output logic              dma_mode,
  output logic              rx_irq
);
  trig_e trig_q;
  logic  rx_clr, tx_clr;

  ufc_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .en_q     (fifo_en),
    .dma_q    (dma_mode),
    .trig_q   (trig_q),
    .rx_clr_q (rx_clr),
    .tx_clr_q (tx_clr)
  );

  ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_clr),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .count (rx_count),
    .drop  (rx_overrun)
  );

  ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .clr   (tx_clr),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .count (tx_count),
    .drop  (tx_overrun)
  );

  ufc_trigger #(.CNT_W(CNT_W)) u_trig (
    .en    (fifo_en),
    .trig  (trig_q),
    .count (rx_count),
    .irq   (rx_irq)
  );
endmodule

// File: rtl/ufc_chk.sv
`timescale 1ns/1ps
module ufc_chk #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [7:0]       cfg_wdata,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_overrun,
  input logic             tx_push,
  input logic [CNT_W-1:0] tx_count,
  input logic             tx_overrun,
  input logic             fifo_en,
  input logic             dma_mode,
  input logic             rx_irq
);
  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_wdata[0] |=> fifo_en && (dma_mode == $past(cfg_wdata[3])));
  // R3
  disable_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && !cfg_wdata[0] |=> !fifo_en && !dma_mode);
  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_wdata[0] && cfg_wdata[1] |-> ##2 (rx_count == '0));
  // R5
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_wdata[0] && cfg_wdata[2] |-> ##2 (tx_count == '0));
  // R7
  irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count == '0 |-> !rx_irq);
  // R7
  irq_top_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count >= CNT_W'(14) |-> rx_irq);
  // R8
  irq_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_en && rx_count != '0 |-> rx_irq);
  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH) && tx_count <= CNT_W'(DEPTH));
  // R10
  rx_overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> $past(rx_push) && $past(rx_count) == CNT_W'(DEPTH));
  // R10
  tx_overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_overrun |-> $past(tx_push) && $past(tx_count) == CNT_W'(DEPTH));
  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count == '0 && rx_pop && !rx_push |=> rx_count == '0);
endmodule

bind uart_fifo_ctl ufc_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_uart_fifo_ctl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_wdata = '0, tx_wdata = '0;
  logic [7:0] rx_rdata, tx_rdata;
  logic [4:0] rx_count, tx_count;
  logic       rx_overrun, tx_overrun, fifo_en, dma_mode, rx_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_fifo_ctl u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rxp(input logic [7:0] d);
    rx_push = 1'b1; rx_wdata = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic rxr();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic txp(input logic [7:0] d);
    tx_push = 1'b1; tx_wdata = d;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic txr();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  function automatic int lvl(input int t);
    case (t)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int t, input int i);
    return 8'((t * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 fifo_en", fifo_en, 0);
    check("R1 dma_mode", dma_mode, 0);
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 overrun", rx_overrun | tx_overrun, 0);

    // R11 pop from empty
    rxr();
    check("R11 rx_count", rx_count, 0);
    txr();
    check("R11 tx_count", tx_count, 0);

    // R7 R9 R10 R6: sweep all trigger levels
    for (int t = 0; t < 4; t++) begin
      wr({2'(t), ((t % 2) == 1) ? 2'b11 : 2'b00, 4'b0011});
      idle(1);
      check("R4 rx_count after clear", rx_count, 0);
      check("R6 fifo_en", fifo_en, 1);
      check("R6 dma_mode", dma_mode, 0);
      for (int i = 0; i < 16; i++) begin
        rxp(pat(t, i));
        check("R9 rx_count fill", rx_count, i + 1);
        check("R7 rx_irq fill", rx_irq, (i + 1 >= lvl(t)) ? 1 : 0);
      end
      rxp(8'hEE);
      check("R10 rx_overrun pulse", rx_overrun, 1);
      check("R10 rx_count full", rx_count, 16);
      idle(1);
      check("R10 rx_overrun single", rx_overrun, 0);
      for (int i = 0; i < 16; i++) begin
        check("R9 rx_rdata order", rx_rdata, pat(t, i));
        check("R7 rx_irq drain", rx_irq, (16 - i >= lvl(t)) ? 1 : 0);
        rxr();
      end
      check("R9 rx_count drained", rx_count, 0);
      check("R7 rx_irq empty", rx_irq, 0);
    end

    // R2 DMA mode select
    wr(8'h09);
    check("R2 dma_mode set", dma_mode, 1);
    check("R2 fifo_en", fifo_en, 1);
    wr(8'h01);
    check("R2 dma_mode clear", dma_mode, 0);

    // R3 R8: disabled write ignores other bits
    wr(8'hC1);
    rxp(8'h11); rxp(8'h22); rxp(8'h33);
    txp(8'h44); txp(8'h55);
    check("R7 level14 rx_irq", rx_irq, 0);
    wr(8'hCE);
    idle(1);
    check("R3 fifo_en", fifo_en, 0);
    check("R3 dma_mode", dma_mode, 0);
    check("R3 rx_count kept", rx_count, 3);
    check("R3 tx_count kept", tx_count, 2);
    check("R8 rx_irq disabled", rx_irq, 1);

    // R5 transmit clear leaves receive alone
    wr(8'h05);
    idle(1);
    check("R5 tx_count", tx_count, 0);
    check("R5 rx_count", rx_count, 3);
    check("R5 rx_rdata", rx_rdata, 8'h11);

    // R12 clear beats a push on the same edge; R4 self-clearing
    wr(8'h03);
    rxp(8'h77);
    check("R12 rx_count", rx_count, 0);
    rxp(8'hA5);
    check("R4 self-clear rx_count", rx_count, 1);
    check("R4 self-clear rx_rdata", rx_rdata, 8'hA5);

    // R9 R10 transmit FIFO
    for (int i = 0; i < 16; i++) txp(pat(5, i));
    check("R9 tx_count full", tx_count, 16);
    txp(8'h99);
    check("R10 tx_overrun pulse", tx_overrun, 1);
    check("R10 tx_count full", tx_count, 16);
    idle(1);
    check("R10 tx_overrun single", tx_overrun, 0);
    for (int i = 0; i < 16; i++) begin
      check("R9 tx_rdata order", tx_rdata, pat(5, i));
      txr();
    end
    check("R9 tx_count drained", tx_count, 0);

    finish_run();
  end
endmodule